// File: doc/BRIEF.md
# Read-after-write interlock for a six-stage add pipeline

This block is a small in-order pipeline that executes only register-to-register additions, built around its hazard logic. Its stages are fetch, decode, register access, a first add stage, a second add stage and writeback. The adder is split in two: the first add stage sums the low half of the operands and produces a carry, and the second add stage sums the upper half with that carry. A sum is therefore complete only at the end of the second add stage.

The interlock compares the two source registers of the instruction in register access with the destinations of the older adds still in flight. A producer one position ahead, still in the first add stage, cannot be bypassed in time. The block then holds the program counter and the decode and register-access stages for one cycle and sends a bubble into the first add stage. Producers two or three positions ahead are bypassed: one from the output of the second add stage, the other from the writeback register. No instruction is ever dropped.

The surrounding code feeds the instruction word that belongs to the program counter the block drives. It watches the stall flag, the two operand-source selects and the writeback port.

Top module: `raw_interlock_pipe`

## Requirements
- R1: After reset, a fresh add instruction taken at program-counter position k appears on the writeback port (wbValid high) right after clock edge 5 + k + B. Edges are counted from the first edge with reset released. B is the number of stall bubbles raised for instructions 0..k.
- R2: The program counter starts at 0 and grows by one on every edge whose preceding cycle had no stall. It keeps its value across an edge that follows a stall cycle.
- R3: stall is high in a cycle exactly when the register-access instruction is an add and the add in the first add stage writes a register equal to either of its sources. This costs exactly one bubble: stall is never high in two consecutive cycles.
- R4: No stall is raised when the older instruction is a no-op, even if its destination field matches. No stall is raised when the younger instruction is a no-op, even if its source fields match.
- R5: A source written by the add in the second add stage is taken from that stage's result (select code 1) with no stall.
- R6: A source written by the add in writeback, and by no add in the second add stage, is taken from the writeback value (select code 2).
- R7: A source with no matching add in the second add stage or in writeback is read from the register file (select code 0). When both of those stages write the same register, the second add stage wins.
- R8: Each writeback value equals the sum of its two source registers as left by all earlier adds in program order, modulo 2^XLEN. The carry between the two adder halves is included. Register i holds i+1 after reset.
- R9: Every add writes back exactly once, in program order. A stall discards nothing.
- R10: Instruction word: bit 3*REG_BITS set marks an add, else a no-op. The destination sits in bits [3*REG_BITS-1:2*REG_BITS], source one in [2*REG_BITS-1:REG_BITS] and source two in [REG_BITS-1:0]. During reset, stall and wbValid are low and the program counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| instrWord | input | 3*REG_BITS+1 | Instruction at the current program counter |
| fetchPc | output | PC_BITS | Program counter of the fetch stage |
| stall | output | 1 | Hazard hold; a bubble enters the first add stage |
| fwdSelA | output | 2 | Source select for operand one (0 file, 1 add stage 2, 2 writeback) |
| fwdSelB | output | 2 | Source select for operand two, same codes |
| wbValid | output | 1 | An add is retiring this cycle |
| wbRd | output | REG_BITS | Destination of the retiring add |
| wbData | output | XLEN | Result of the retiring add |

## Verification
The bench uses the default XLEN of 16, REG_BITS of 3 and PC_BITS of 8. Eight registers let short programs hit every distance from one to three between producer and consumer. They also let two in-flight adds target the same register, which reaches the priority case. With 8-bit halves, a chain of doubling adds crosses 255 within eight instructions, so the carry between the two adder stages is exercised under back-to-back stalls.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  // Where an operand of the register-access instruction comes from.
  typedef enum logic [1:0] {
    SRC_RF   = 2'd0,
    SRC_ADD2 = 2'd1,
    SRC_WB   = 2'd2
  } opnd_src_e;

  // Strobes from the hazard control to the datapath.
  typedef struct packed {
    logic      hold;   // freeze fetch/decode/access, bubble into add stage 1
    opnd_src_e srcA;
    opnd_src_e srcB;
  } ilk_strobe_t;

endpackage

// File: rtl/ilk_ctrl.sv
module ilk_ctrl
  import ilk_pkg::*;
#(
  parameter int REG_BITS = 3
) (
  input  logic                raIsAdd,
  input  logic [REG_BITS-1:0] raRs1,
  input  logic [REG_BITS-1:0] raRs2,
  input  logic                a1IsAdd,
  input  logic [REG_BITS-1:0] a1Rd,
  input  logic                a2IsAdd,
  input  logic [REG_BITS-1:0] a2Rd,
  input  logic                wbIsAdd,
  input  logic [REG_BITS-1:0] wbRd,
  output ilk_strobe_t         strobe
);

  localparam int NOPND = 2;

  logic [REG_BITS-1:0] srcReg [NOPND];
  logic [NOPND-1:0]    nearHit;
  opnd_src_e           srcSel [NOPND];

  assign srcReg[0] = raRs1;
  assign srcReg[1] = raRs2;

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    // Producer one slot ahead: its sum is not ready in time.
    assign nearHit[g] = a1IsAdd && (a1Rd == srcReg[g]);
    // Youngest complete producer wins.
    assign srcSel[g]  = (a2IsAdd && (a2Rd == srcReg[g])) ? SRC_ADD2 :
                        (wbIsAdd && (wbRd == srcReg[g])) ? SRC_WB   : SRC_RF;
  end

  always_comb begin
    strobe.hold = raIsAdd && (|nearHit);
    strobe.srcA = srcSel[0];
    strobe.srcB = srcSel[1];
  end

endmodule

// File: rtl/ilk_dpath.sv
module ilk_dpath
  import ilk_pkg::*;
#(
  parameter int XLEN     = 16,
  parameter int REG_BITS = 3,
  parameter int PC_BITS  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [3*REG_BITS:0]   instrWord,
  input  ilk_strobe_t           strobe,
  output logic [PC_BITS-1:0]    fetchPc,
  output logic                  raIsAdd,
  output logic [REG_BITS-1:0]   raRs1,
  output logic [REG_BITS-1:0]   raRs2,
  output logic                  a1IsAdd,
  output logic [REG_BITS-1:0]   a1Rd,
  output logic                  a2IsAdd,
  output logic [REG_BITS-1:0]   a2Rd,
  output logic                  wbIsAdd,
  output logic [REG_BITS-1:0]   wbRd,
  output logic [XLEN-1:0]       wbData
);

  localparam int IW    = 3 * REG_BITS + 1;
  localparam int NREGS = 1 << REG_BITS;
  localparam int LO    = XLEN / 2;
  localparam int HI    = XLEN - LO;

  logic [PC_BITS-1:0]  pcQ;
  logic [IW-1:0]       decWord, raWord;
  logic [REG_BITS-1:0] raRd;
  logic [XLEN-1:0]     rf [NREGS];

  logic [XLEN-1:0]     a1OpA, a1OpB;
  logic [LO:0]         a1LoSum;

  logic [LO-1:0]       a2Lo;
  logic                a2Carry;
  logic [HI-1:0]       a2AHi, a2BHi;
  logic [XLEN-1:0]     a2Result;

  logic [XLEN-1:0]     opA, opB;

  // Register-access fields
  assign raIsAdd = raWord[IW-1];
  assign raRd    = raWord[3*REG_BITS-1:2*REG_BITS];
  assign raRs1   = raWord[2*REG_BITS-1:REG_BITS];
  assign raRs2   = raWord[REG_BITS-1:0];
  assign fetchPc = pcQ;

  function automatic logic [XLEN-1:0] pickOpnd(input opnd_src_e sel,
                                               input logic [XLEN-1:0] fromRf,
                                               input logic [XLEN-1:0] fromA2,
                                               input logic [XLEN-1:0] fromWb);
    case (sel)
      SRC_ADD2: return fromA2;
      SRC_WB:   return fromWb;
      default:  return fromRf;
    endcase
  endfunction

  assign opA = pickOpnd(strobe.srcA, rf[raRs1], a2Result, wbData);
  assign opB = pickOpnd(strobe.srcB, rf[raRs2], a2Result, wbData);

  // Split adder
  assign a1LoSum  = {1'b0, a1OpA[LO-1:0]} + {1'b0, a1OpB[LO-1:0]};
  assign a2Result = {a2AHi + a2BHi + HI'(a2Carry), a2Lo};

  // Fetch, decode, register access: frozen together on a hold
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ     <= '0;
      decWord <= '0;
      raWord  <= '0;
    end else if (!strobe.hold) begin
      pcQ     <= pcQ + 1'b1;
      decWord <= instrWord;
      raWord  <= decWord;
    end
  end

  // Add stages and writeback always advance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      a1IsAdd <= 1'b0;
      a1Rd    <= '0;
      a1OpA   <= '0;
      a1OpB   <= '0;
      a2IsAdd <= 1'b0;
      a2Rd    <= '0;
      a2Lo    <= '0;
      a2Carry <= 1'b0;
      a2AHi   <= '0;
      a2BHi   <= '0;
      wbIsAdd <= 1'b0;
      wbRd    <= '0;
      wbData  <= '0;
    end else begin
      a1IsAdd <= raIsAdd && !strobe.hold;
      a1Rd    <= raRd;
      a1OpA   <= opA;
      a1OpB   <= opB;
      a2IsAdd <= a1IsAdd;
      a2Rd    <= a1Rd;
      a2Lo    <= a1LoSum[LO-1:0];
      a2Carry <= a1LoSum[LO];
      a2AHi   <= a1OpA[XLEN-1:LO];
      a2BHi   <= a1OpB[XLEN-1:LO];
      wbIsAdd <= a2IsAdd;
      wbRd    <= a2Rd;
      wbData  <= a2Result;
    end
  end

  // Register file, written at the end of writeback
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREGS; i++) rf[i] <= XLEN'(i + 1);
    end else if (wbIsAdd) begin
      rf[wbRd] <= wbData;
    end
  end

endmodule

// File: rtl/raw_interlock_pipe.sv
module raw_interlock_pipe
  import ilk_pkg::*;
#(
  parameter int XLEN     = 16,
  parameter int REG_BITS = 3,
  parameter int PC_BITS  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [3*REG_BITS:0] instrWord,
  output logic [PC_BITS-1:0]  fetchPc,
  output logic                stall,
  output logic [1:0]          fwdSelA,
  output logic [1:0]          fwdSelB,
  output logic                wbValid,
  output logic [REG_BITS-1:0] wbRd,
  output logic [XLEN-1:0]     wbData
);

  ilk_strobe_t         strobe;
  logic                raIsAdd, a1IsAdd, a2IsAdd;
  logic [REG_BITS-1:0] raRs1, raRs2, a1Rd, a2Rd;

  ilk_ctrl #(.REG_BITS(REG_BITS)) u_ctrl (
    .raIsAdd (raIsAdd),
    .raRs1   (raRs1),
    .raRs2   (raRs2),
    .a1IsAdd (a1IsAdd),
    .a1Rd    (a1Rd),
    .a2IsAdd (a2IsAdd),
    .a2Rd    (a2Rd),
    .wbIsAdd (wbValid),
    .wbRd    (wbRd),
    .strobe  (strobe)
  );

  ilk_dpath #(.XLEN(XLEN), .REG_BITS(REG_BITS), .PC_BITS(PC_BITS)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .instrWord (instrWord),
    .strobe    (strobe),
    .fetchPc   (fetchPc),
    .raIsAdd   (raIsAdd),
    .raRs1     (raRs1),
    .raRs2     (raRs2),
    .a1IsAdd   (a1IsAdd),
    .a1Rd      (a1Rd),
    .a2IsAdd   (a2IsAdd),
    .a2Rd      (a2Rd),
    .wbIsAdd   (wbValid),
    .wbRd      (wbRd),
    .wbData    (wbData)
  );

  assign stall   = strobe.hold;
  assign fwdSelA = strobe.srcA;
  assign fwdSelB = strobe.srcB;

endmodule

// File: rtl/ilk_checker.sv
module ilk_checker #(
  parameter int REG_BITS = 3,
  parameter int PC_BITS  = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                stall,
  input logic [PC_BITS-1:0]  fetchPc,
  input logic [1:0]          srcA,
  input logic [1:0]          srcB,
  input logic                raIsAdd,
  input logic [REG_BITS-1:0] raRs1,
  input logic [REG_BITS-1:0] raRs2,
  input logic                a1IsAdd,
  input logic                a2IsAdd,
  input logic [REG_BITS-1:0] a2Rd,
  input logic                wbValid,
  input logic [REG_BITS-1:0] wbRd
);

  p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(fetchPc));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stall |=> fetchPc == PC_BITS'($past(fetchPc) + 1'b1));

  p_one_bubble_r3: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !stall);

  p_bubble_in_r3: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !a1IsAdd);

  p_access_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> ($stable(raRs1) && $stable(raRs2) && raIsAdd));

  p_fwd_add2_r5: assert property (@(posedge clk) disable iff (!rstN)
    (srcA == 2'd1) |-> (a2IsAdd && a2Rd == raRs1));

  p_fwd_wb_r6: assert property (@(posedge clk) disable iff (!rstN)
    (srcB == 2'd2) |-> (wbValid && wbRd == raRs2 && !(a2IsAdd && a2Rd == raRs2)));

endmodule

bind raw_interlock_pipe ilk_checker #(.REG_BITS(REG_BITS), .PC_BITS(PC_BITS)) u_ilkChk (
  .clk     (clk),
  .rstN    (rstN),
  .stall   (stall),
  .fetchPc (fetchPc),
  .srcA    (fwdSelA),
  .srcB    (fwdSelB),
  .raIsAdd (raIsAdd),
  .raRs1   (raRs1),
  .raRs2   (raRs2),
  .a1IsAdd (a1IsAdd),
  .a2IsAdd (a2IsAdd),
  .a2Rd    (a2Rd),
  .wbValid (wbValid),
  .wbRd    (wbRd)
);

// File: tb/tb_raw_interlock_pipe.sv
`timescale 1ns/1ps
module tb_raw_interlock_pipe;

  localparam int XLEN  = 16;
  localparam int RB    = 3;
  localparam int PCB   = 8;
  localparam int IW    = 3 * RB + 1;
  localparam int PLEN  = 8;
  localparam int NPROG = 8;
  localparam int NCYC  = 24;

  // R10 encoding: {add, rd, rs1, rs2}
  localparam logic [IW-1:0] PROG_TBL [NPROG][PLEN] = '{
    '{ {1'b1,3'd3,3'd1,3'd2}, {1'b1,3'd4,3'd5,3'd6}, {1'b1,3'd7,3'd1,3'd1}, {1'b1,3'd0,3'd2,3'd5},
       10'd0, 10'd0, 10'd0, 10'd0 },
    '{ {1'b1,3'd3,3'd1,3'd2}, {1'b1,3'd2,3'd3,3'd1}, {1'b1,3'd1,3'd3,3'd4}, 10'd0,
       10'd0, 10'd0, 10'd0, 10'd0 },
    '{ {1'b1,3'd3,3'd1,3'd2}, {1'b1,3'd4,3'd5,3'd6}, {1'b1,3'd5,3'd3,3'd3}, {1'b1,3'd6,3'd3,3'd4},
       10'd0, 10'd0, 10'd0, 10'd0 },
    '{ {1'b1,3'd1,3'd1,3'd1}, {1'b1,3'd1,3'd1,3'd2}, {1'b1,3'd2,3'd1,3'd1}, {1'b1,3'd3,3'd2,3'd0},
       10'd0, 10'd0, 10'd0, 10'd0 },
    '{ {1'b1,3'd2,3'd1,3'd1}, {1'b0,3'd2,3'd0,3'd0}, {1'b1,3'd6,3'd2,3'd2}, {1'b1,3'd7,3'd6,3'd1},
       {1'b0,3'd0,3'd7,3'd7}, {1'b1,3'd0,3'd7,3'd7}, 10'd0, 10'd0 },
    '{ {1'b1,3'd5,3'd1,3'd2}, {1'b1,3'd6,3'd0,3'd5}, {1'b1,3'd7,3'd6,3'd6}, 10'd0,
       10'd0, 10'd0, 10'd0, 10'd0 },
    '{ {1'b1,3'd1,3'd2,3'd3}, {1'b1,3'd1,3'd4,3'd5}, {1'b1,3'd6,3'd2,3'd2}, {1'b1,3'd7,3'd1,3'd1},
       10'd0, 10'd0, 10'd0, 10'd0 },
    '{ {1'b1,3'd1,3'd1,3'd1}, {1'b1,3'd1,3'd1,3'd1}, {1'b1,3'd1,3'd1,3'd1}, {1'b1,3'd1,3'd1,3'd1},
       {1'b1,3'd1,3'd1,3'd1}, {1'b1,3'd1,3'd1,3'd1}, {1'b1,3'd1,3'd1,3'd1}, {1'b1,3'd1,3'd1,3'd1} }
  };
  localparam int EXP_BUB [NPROG] = '{0, 1, 0, 3, 1, 2, 0, 7};

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [IW-1:0]   instrWord;
  logic [PCB-1:0]  fetchPc;
  logic            stall;
  logic [1:0]      fwdSelA, fwdSelB;
  logic            wbValid;
  logic [RB-1:0]   wbRd;
  logic [XLEN-1:0] wbData;

  logic [IW-1:0]   cur [PLEN];
  int              checks = 0;
  int              fails  = 0;

  always #10 clk = ~clk;

  assign instrWord = (fetchPc < PCB'(PLEN)) ? cur[fetchPc[2:0]] : '0;

  raw_interlock_pipe #(.XLEN(XLEN), .REG_BITS(RB), .PC_BITS(PCB)) dut (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .fetchPc(fetchPc),
    .stall(stall), .fwdSelA(fwdSelA), .fwdSelB(fwdSelB),
    .wbValid(wbValid), .wbRd(wbRd), .wbData(wbData)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int p = 0; p < NPROG; p++) begin
      logic [XLEN-1:0] mrf [8];
      logic [RB-1:0]   expRd [PLEN];
      logic [XLEN-1:0] expData [PLEN];
      int              expCyc [PLEN];
      int              nExp, bub, seen, stalls;
      logic [PCB-1:0]  prevPc;
      logic            prevStall;

      for (int k = 0; k < PLEN; k++) cur[k] = PROG_TBL[p][k];

      // Sequential model from R8 and the bubble rule of R3/R4
      for (int r = 0; r < 8; r++) mrf[r] = XLEN'(r + 1);
      nExp = 0; bub = 0;
      for (int k = 0; k < PLEN; k++) begin
        logic [IW-1:0] w;
        w = cur[k];
        if (k > 0 && w[9] && cur[k-1][9] &&
            (cur[k-1][8:6] == w[5:3] || cur[k-1][8:6] == w[2:0])) bub++;
        if (w[9]) begin
          expData[nExp] = mrf[w[5:3]] + mrf[w[2:0]];
          expRd[nExp]   = w[8:6];
          expCyc[nExp]  = 5 + k + bub;
          mrf[w[8:6]]   = expData[nExp];
          nExp++;
        end
      end

      // Reset state (R10)
      rstN = 1'b0;
      repeat (2) @(negedge clk);
      chk("R10 reset stall", int'(stall), 0);
      chk("R10 reset wbValid", int'(wbValid), 0);
      chk("R10 reset pc", int'(fetchPc), 0);
      rstN = 1'b1;

      seen = 0; stalls = 0; prevPc = '0; prevStall = 1'b0;
      for (int e = 1; e <= NCYC; e++) begin
        @(negedge clk);
        // R2: program counter steps or holds
        chk($sformatf("R2 pc p%0d e%0d", p, e), int'(fetchPc),
            prevStall ? int'(prevPc) : int'(PCB'(prevPc + 1'b1)));
        prevPc = fetchPc;
        prevStall = stall;
        if (stall) stalls++;

        if (wbValid) begin
          if (seen < nExp) begin
            chk($sformatf("R8 data p%0d #%0d", p, seen), int'(wbData), int'(expData[seen]));
            chk($sformatf("R9 rd p%0d #%0d", p, seen), int'(wbRd), int'(expRd[seen]));
            chk($sformatf("R1 cycle p%0d #%0d", p, seen), e, expCyc[seen]);
          end else begin
            chk($sformatf("R9 extra writeback p%0d", p), seen + 1, nExp);
          end
          seen++;
        end

        // Directed operand-source checks
        if (p == 1 && e == 3) chk("R3 stall at distance one", int'(stall), 1);
        if (p == 1 && e == 4) begin
          chk("R3 single bubble", int'(stall), 0);
          chk("R5 srcA after bubble", int'(fwdSelA), 1);
          chk("R7 srcB register file", int'(fwdSelB), 0);
        end
        if (p == 2 && e == 4) begin
          chk("R5 srcA distance two", int'(fwdSelA), 1);
          chk("R5 srcB distance two", int'(fwdSelB), 1);
          chk("R5 no stall distance two", int'(stall), 0);
        end
        if (p == 2 && e == 5) begin
          chk("R6 srcA distance three", int'(fwdSelA), 2);
          chk("R5 srcB distance two", int'(fwdSelB), 1);
        end
        if (p == 6 && e == 5) begin
          chk("R7 priority srcA", int'(fwdSelA), 1);
          chk("R7 priority srcB", int'(fwdSelB), 1);
        end
      end

      chk($sformatf("R3 R4 bubble count p%0d", p), stalls, EXP_BUB[p]);
      chk($sformatf("R9 writeback count p%0d", p), seen, nExp);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule